// File: doc/BRIEF.md
# Inter-Cluster Request Forwarding Controller

This block sits between the snoop paths of two bus clusters and decides, for each request that the local cluster buffers, whether and how that request reaches the neighbouring cluster. System software picks one of three operating modes at run time. In the sealed mode nothing crosses to the neighbour. In the speculative mode a request goes straight onto the neighbour's snoop bus in parallel with the local snoop. In the deferred mode the neighbour only parks the request, and it is released or dropped once the local combined snoop result is known.

For every forwarded request the block drives a two-output routing switch, the select of the neighbour's snoop-bus input multiplexer, and store, issue, discard and hold controls for the neighbour's request queue. A small table of pending tags matches each local combined result to the entry it belongs to. A mode change is held back until no forwarded request is pending. Every control output comes from a register, so each decision appears one bus cycle after its cause.

Top module: `xclu_fwd_ctrl`

## Requirements
- R1: After reset the active mode is sealed (code 0), `busy` is low, and every neighbour control output is low.
- R2: While the sealed mode (code 0) is active, a local request produces no switch enable, no forward strobe and no store, hold, issue or discard.
- R3: The two switch enables `sw_en_spec` and `sw_en_defer` are never high together. Each forwarded request raises exactly one of them, for one cycle.
- R4: In the speculative mode (code 1), a request sampled in cycle t raises `sw_en_spec`, `nb_mux_sel`, `nb_hold` and `nb_fwd_valid` in cycle t+1 for one cycle, with the request's tag and address on `nb_fwd_tag`/`nb_fwd_addr`. `nb_store` stays low.
- R5: In the deferred mode (code 2), a request sampled in cycle t raises `sw_en_defer`, `nb_store` and `nb_fwd_valid` in cycle t+1, with its tag and address. `nb_mux_sel`, `nb_hold` and `nb_issue` stay low.
- R6: A combined result with `cmb_served` low whose tag matches a pending deferred entry raises `nb_issue` one cycle later, with that tag on `nb_ctl_tag`, and frees the entry.
- R7: A combined result with `cmb_served` high whose tag matches a pending deferred entry raises `nb_discard` (not `nb_issue`) one cycle later, with that tag on `nb_ctl_tag`, and frees the entry.
- R8: A combined result whose tag matches no pending entry, or that matches a speculative entry, raises neither `nb_issue` nor `nb_discard`. A matched speculative entry is freed.
- R9: At most DEPTH forwarded requests are pending at a time. A request that arrives while all entries are in use is not forwarded: no output reacts to it.
- R10: Writing a mode code of 0, 1 or 2 raises `busy` in the next cycle. The new mode appears on `cur_mode`, and `busy` falls, one cycle after a cycle in which `busy` was high and no entry was pending. A write of code 3 is ignored.
- R11: A request arriving in a cycle in which `busy` is high is not forwarded.
- R12: A tag is CORE_W+RID_W bits wide, with the originating core ID in the upper CORE_W bits and the request ID in the lower RID_W bits. It passes unchanged to `nb_fwd_tag` and `nb_ctl_tag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Mode write strobe from software |
| cfg_mode | input | 2 | Mode code to write: 0 sealed, 1 speculative, 2 deferred |
| cur_mode | output | 2 | Mode currently applied |
| busy | output | 1 | A mode write is waiting for pending entries to drain |
| req_valid | input | 1 | Local cluster buffered a request this cycle |
| req_tag | input | CORE_W+RID_W | Tag of the local request |
| req_addr | input | ADDR_W | Address of the local request |
| cmb_valid | input | 1 | Local combined snoop result is valid |
| cmb_tag | input | CORE_W+RID_W | Tag the combined result refers to |
| cmb_served | input | 1 | High if a local cache can serve the request |
| sw_en_spec | output | 1 | Switch drives the speculative path |
| sw_en_defer | output | 1 | Switch drives the deferred path |
| nb_mux_sel | output | 1 | Neighbour snoop mux selects the forwarded input |
| nb_hold | output | 1 | Neighbour queue must not issue this cycle |
| nb_fwd_valid | output | 1 | Forwarded request present on the switch output |
| nb_fwd_tag | output | CORE_W+RID_W | Tag of the forwarded request |
| nb_fwd_addr | output | ADDR_W | Address of the forwarded request |
| nb_store | output | 1 | Neighbour queue stores the forwarded request |
| nb_issue | output | 1 | Neighbour queue issues the stored entry named by nb_ctl_tag |
| nb_discard | output | 1 | Neighbour queue drops the stored entry named by nb_ctl_tag |
| nb_ctl_tag | output | CORE_W+RID_W | Tag for the issue or discard pulse |

## Verification
The assertions rely on the local cluster never having two pending forwarded requests with the same tag, and on a combined result arriving only after its request was forwarded, one cycle later at the earliest. The stimulus uses a fresh tag for every open request and sends each combined result at least one cycle after the forward appears. It also aims some results at tags that were never forwarded, to check that such results are ignored. Mode writes are issued both with the table empty and with an entry pending, so that the drain path is covered.

// File: rtl/xclu_pkg.sv
package xclu_pkg;
    localparam int CORE_W = 3;
    localparam int RID_W  = 5;
    localparam int TAG_W  = CORE_W + RID_W;

    typedef enum logic [1:0] {
        MODE_SEALED = 2'd0,
        MODE_SPEC   = 2'd1,
        MODE_DEFER  = 2'd2
    } mode_e;

    typedef logic [TAG_W-1:0] tag_t;
endpackage

// File: rtl/xclu_free_slot.sv
module xclu_free_slot #(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] used,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!used[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xclu_tag_match.sv
module xclu_tag_match #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]            live,
    input  logic [DEPTH-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            probe,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);
    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = live[g] && (tags[g] == probe);
    end

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xclu_fwd_ctrl.sv
module xclu_fwd_ctrl
    import xclu_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_mode,
    output logic [1:0]        cur_mode,
    output logic              busy,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cmb_valid,
    input  logic [TAG_W-1:0]  cmb_tag,
    input  logic              cmb_served,
    output logic              sw_en_spec,
    output logic              sw_en_defer,
    output logic              nb_mux_sel,
    output logic              nb_hold,
    output logic              nb_fwd_valid,
    output logic [TAG_W-1:0]  nb_fwd_tag,
    output logic [ADDR_W-1:0] nb_fwd_addr,
    output logic              nb_store,
    output logic              nb_issue,
    output logic              nb_discard,
    output logic [TAG_W-1:0]  nb_ctl_tag
);
    typedef struct packed {
        logic              sw_spec;
        logic              sw_defer;
        logic              mux_sel;
        logic              hold;
        logic              fwd_valid;
        tag_t              fwd_tag;
        logic [ADDR_W-1:0] fwd_addr;
        logic              store;
        logic              issue;
        logic              discard;
        tag_t              ctl_tag;
    } ctl_t;

    typedef struct packed {
        mode_e                   mode;
        logic                    pend;
        mode_e                   pend_mode;
        logic [DEPTH-1:0]        live;
        logic [DEPTH-1:0]        spec;
        logic [DEPTH-1:0][TAG_W-1:0] tags;
        ctl_t                    ctl;
    } state_t;

    state_t s_d, s_q;

    logic             slot_found;
    logic [IDX_W-1:0] slot_idx;
    logic             match_hit;
    logic [IDX_W-1:0] match_idx;
    logic             cfg_legal;
    logic             fwd_ok;

    xclu_free_slot #(.DEPTH(DEPTH)) u_free (
        .used  (s_q.live),
        .found (slot_found),
        .idx   (slot_idx)
    );

    xclu_tag_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_match (
        .live  (s_q.live),
        .tags  (s_q.tags),
        .probe (cmb_tag),
        .hit   (match_hit),
        .idx   (match_idx)
    );

    assign cfg_legal = (cfg_mode != 2'd3);
    assign fwd_ok    = req_valid && (s_q.mode != MODE_SEALED) && !s_q.pend && slot_found;

    always_comb begin
        s_d     = s_q;
        s_d.ctl = '0;

        // resolve a combined result against the pending table
        if (cmb_valid && match_hit) begin
            s_d.live[match_idx] = 1'b0;
            if (!s_q.spec[match_idx]) begin
                s_d.ctl.issue   = !cmb_served;
                s_d.ctl.discard = cmb_served;
                s_d.ctl.ctl_tag = cmb_tag;
            end
        end

        // steer a new local request
        if (fwd_ok) begin
            s_d.live[slot_idx] = 1'b1;
            s_d.spec[slot_idx] = (s_q.mode == MODE_SPEC);
            s_d.tags[slot_idx] = req_tag;
            s_d.ctl.fwd_valid  = 1'b1;
            s_d.ctl.fwd_tag    = req_tag;
            s_d.ctl.fwd_addr   = req_addr;
            if (s_q.mode == MODE_SPEC) begin
                s_d.ctl.sw_spec = 1'b1;
                s_d.ctl.mux_sel = 1'b1;
                s_d.ctl.hold    = 1'b1;
            end else begin
                s_d.ctl.sw_defer = 1'b1;
                s_d.ctl.store    = 1'b1;
            end
        end

        // apply a waiting mode once the table has drained
        if (s_q.pend && (s_q.live == '0)) begin
            s_d.mode = s_q.pend_mode;
            s_d.pend = 1'b0;
        end

        if (cfg_wr && cfg_legal) begin
            s_d.pend      = 1'b1;
            s_d.pend_mode = mode_e'(cfg_mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= MODE_SEALED;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_mode     = s_q.mode;
    assign busy         = s_q.pend;
    assign sw_en_spec   = s_q.ctl.sw_spec;
    assign sw_en_defer  = s_q.ctl.sw_defer;
    assign nb_mux_sel   = s_q.ctl.mux_sel;
    assign nb_hold      = s_q.ctl.hold;
    assign nb_fwd_valid = s_q.ctl.fwd_valid;
    assign nb_fwd_tag   = s_q.ctl.fwd_tag;
    assign nb_fwd_addr  = s_q.ctl.fwd_addr;
    assign nb_store     = s_q.ctl.store;
    assign nb_issue     = s_q.ctl.issue;
    assign nb_discard   = s_q.ctl.discard;
    assign nb_ctl_tag   = s_q.ctl.ctl_tag;
endmodule

// File: rtl/xclu_fwd_ctrl_chk.sv
module xclu_fwd_ctrl_chk #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cur_mode,
    input logic             busy,
    input logic             cmb_valid,
    input logic [TAG_W-1:0] cmb_tag,
    input logic             cmb_served,
    input logic             sw_en_spec,
    input logic             sw_en_defer,
    input logic             nb_mux_sel,
    input logic             nb_hold,
    input logic             nb_fwd_valid,
    input logic             nb_store,
    input logic             nb_issue,
    input logic             nb_discard,
    input logic [TAG_W-1:0] nb_ctl_tag,
    input logic [DEPTH-1:0] tbl_live
);
    a_r2_sealed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 2'd0 && $past(cur_mode) == 2'd0) |-> !nb_fwd_valid && !nb_store && !nb_hold);

    a_r3_switch_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_en_spec, sw_en_defer}));

    a_r4_spec_bundle: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en_spec |-> nb_mux_sel && nb_hold && nb_fwd_valid && !nb_store);

    a_r5_defer_bundle: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en_defer |-> nb_store && nb_fwd_valid && !nb_mux_sel && !nb_hold);

    a_r6_issue_cause: assert property (@(posedge clk) disable iff (!rst_n)
        nb_issue |-> $past(cmb_valid) && !$past(cmb_served) && nb_ctl_tag == $past(cmb_tag));

    a_r7_issue_discard_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nb_issue && nb_discard));

    a_r9_no_fwd_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        nb_fwd_valid |-> !(&$past(tbl_live)));

    a_r10_mode_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != $past(cur_mode)) |-> $past(busy));

    a_r11_no_fwd_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !nb_fwd_valid);
endmodule

bind xclu_fwd_ctrl xclu_fwd_ctrl_chk #(.DEPTH(DEPTH), .TAG_W(xclu_pkg::TAG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_mode     (cur_mode),
    .busy         (busy),
    .cmb_valid    (cmb_valid),
    .cmb_tag      (cmb_tag),
    .cmb_served   (cmb_served),
    .sw_en_spec   (sw_en_spec),
    .sw_en_defer  (sw_en_defer),
    .nb_mux_sel   (nb_mux_sel),
    .nb_hold      (nb_hold),
    .nb_fwd_valid (nb_fwd_valid),
    .nb_store     (nb_store),
    .nb_issue     (nb_issue),
    .nb_discard   (nb_discard),
    .nb_ctl_tag   (nb_ctl_tag),
    .tbl_live     (s_q.live)
);

// File: tb/xclu_fwd_ctrl_tb.sv
module xclu_fwd_ctrl_tb;
    import xclu_pkg::*;

    localparam int DEPTH  = 4;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_mode = '0;
    logic [1:0]        cur_mode;
    logic              busy;
    logic              req_valid = 1'b0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              cmb_valid = 1'b0;
    logic [TAG_W-1:0]  cmb_tag = '0;
    logic              cmb_served = 1'b0;
    logic              sw_en_spec, sw_en_defer, nb_mux_sel, nb_hold, nb_fwd_valid;
    logic [TAG_W-1:0]  nb_fwd_tag, nb_ctl_tag;
    logic [ADDR_W-1:0] nb_fwd_addr;
    logic              nb_store, nb_issue, nb_discard;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    xclu_fwd_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cur_mode(cur_mode), .busy(busy), .req_valid(req_valid), .req_tag(req_tag),
        .req_addr(req_addr), .cmb_valid(cmb_valid), .cmb_tag(cmb_tag),
        .cmb_served(cmb_served), .sw_en_spec(sw_en_spec), .sw_en_defer(sw_en_defer),
        .nb_mux_sel(nb_mux_sel), .nb_hold(nb_hold), .nb_fwd_valid(nb_fwd_valid),
        .nb_fwd_tag(nb_fwd_tag), .nb_fwd_addr(nb_fwd_addr), .nb_store(nb_store),
        .nb_issue(nb_issue), .nb_discard(nb_discard), .nb_ctl_tag(nb_ctl_tag)
    );

    function automatic tag_t mk_tag(input int core, input int rid);
        return {core[CORE_W-1:0], rid[RID_W-1:0]};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send_req(input tag_t t, input logic [ADDR_W-1:0] a);
        req_valid = 1'b1; req_tag = t; req_addr = a;
        step();
        req_valid = 1'b0;
    endtask

    task automatic send_cmb(input tag_t t, input logic served);
        cmb_valid = 1'b1; cmb_tag = t; cmb_served = served;
        step();
        cmb_valid = 1'b0;
    endtask

    task automatic write_mode(input logic [1:0] m);
        cfg_wr = 1'b1; cfg_mode = m;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "cur_mode", 64'(cur_mode), 64'd0);
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "controls", 64'({sw_en_spec, sw_en_defer, nb_mux_sel, nb_hold, nb_fwd_valid,
                                   nb_store, nb_issue, nb_discard}), 64'd0);
    endtask

    task automatic t_sealed();
        send_req(mk_tag(1, 3), 32'h1000);
        chk("R2", "fwd/store/hold", 64'({nb_fwd_valid, nb_store, nb_hold}), 64'd0);
        chk("R2", "switch", 64'({sw_en_spec, sw_en_defer}), 64'd0);
        write_mode(2'd3);
        chk("R10", "busy after code 3", 64'(busy), 64'd0);
        step();
        chk("R10", "mode after code 3", 64'(cur_mode), 64'd0);
    endtask

    task automatic t_spec();
        tag_t t = mk_tag(5, 10);
        write_mode(2'd1);
        chk("R10", "busy after write", 64'(busy), 64'd1);
        chk("R10", "mode during busy", 64'(cur_mode), 64'd0);
        step();
        chk("R10", "mode applied", 64'(cur_mode), 64'd1);
        chk("R10", "busy cleared", 64'(busy), 64'd0);
        send_req(t, 32'hCAFE_0040);
        chk("R4", "spec/mux/hold/fwd", 64'({sw_en_spec, nb_mux_sel, nb_hold, nb_fwd_valid}), 64'hF);
        chk("R4", "store", 64'(nb_store), 64'd0);
        chk("R3", "defer switch", 64'(sw_en_defer), 64'd0);
        chk("R4", "addr", 64'(nb_fwd_addr), 64'hCAFE_0040);
        chk("R12", "tag", 64'(nb_fwd_tag), 64'h0AA);
        chk("R12", "core field", 64'(nb_fwd_tag[TAG_W-1 -: CORE_W]), 64'd5);
        step();
        chk("R4", "one-cycle pulse", 64'({sw_en_spec, nb_hold, nb_fwd_valid}), 64'd0);
        send_cmb(t, 1'b0);
        chk("R8", "spec entry no issue/discard", 64'({nb_issue, nb_discard}), 64'd0);
    endtask

    task automatic t_defer();
        tag_t a = mk_tag(2, 7);
        tag_t b = mk_tag(6, 1);
        write_mode(2'd2);
        step();
        chk("R10", "mode defer", 64'(cur_mode), 64'd2);
        send_req(a, 32'h0000_2200);
        chk("R5", "defer/store/fwd", 64'({sw_en_defer, nb_store, nb_fwd_valid}), 64'h7);
        chk("R5", "mux/hold/issue", 64'({nb_mux_sel, nb_hold, nb_issue}), 64'd0);
        chk("R3", "spec switch", 64'(sw_en_spec), 64'd0);
        chk("R5", "tag", 64'(nb_fwd_tag), 64'(a));
        send_cmb(mk_tag(7, 31), 1'b0);
        chk("R8", "unmatched tag", 64'({nb_issue, nb_discard}), 64'd0);
        send_cmb(a, 1'b0);
        chk("R6", "issue", 64'({nb_issue, nb_discard}), 64'h2);
        chk("R6", "issue tag", 64'(nb_ctl_tag), 64'(a));
        send_cmb(a, 1'b0);
        chk("R6", "entry freed", 64'(nb_issue), 64'd0);
        send_req(b, 32'h0000_3300);
        send_cmb(b, 1'b1);
        chk("R7", "discard", 64'({nb_issue, nb_discard}), 64'h1);
        chk("R7", "discard tag", 64'(nb_ctl_tag), 64'(b));
    endtask

    task automatic t_capacity();
        tag_t extra = mk_tag(3, 20);
        for (int i = 0; i < DEPTH; i++) begin
            send_req(mk_tag(4, i), 32'(i));
            chk("R9", "fill store", 64'(nb_store), 64'd1);
        end
        send_req(extra, 32'h55);
        chk("R9", "full blocks fwd", 64'({nb_fwd_valid, nb_store, sw_en_defer}), 64'd0);
        send_cmb(mk_tag(4, 0), 1'b1);
        chk("R9", "discard frees", 64'(nb_discard), 64'd1);
        send_req(extra, 32'h55);
        chk("R9", "store after free", 64'(nb_store), 64'd1);
        for (int i = 1; i < DEPTH; i++) send_cmb(mk_tag(4, i), 1'b1);
        send_cmb(extra, 1'b1);
        chk("R9", "drained", 64'(nb_discard), 64'd1);
    endtask

    task automatic t_drain();
        tag_t a = mk_tag(1, 9);
        send_req(a, 32'h77);
        write_mode(2'd1);
        chk("R10", "busy pending", 64'(busy), 64'd1);
        send_req(mk_tag(1, 12), 32'h78);
        chk("R11", "no fwd while busy", 64'({nb_fwd_valid, nb_store, sw_en_spec}), 64'd0);
        chk("R10", "mode held", 64'(cur_mode), 64'd2);
        send_cmb(a, 1'b0);
        chk("R6", "issue on drain", 64'(nb_issue), 64'd1);
        chk("R10", "still busy", 64'(busy), 64'd1);
        step();
        chk("R10", "mode after drain", 64'(cur_mode), 64'd1);
        chk("R10", "busy after drain", 64'(busy), 64'd0);
        write_mode(2'd0);
        step();
        chk("R10", "back to sealed", 64'(cur_mode), 64'd0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_sealed();
        t_spec();
        t_defer();
        t_capacity();
        t_drain();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule